// File: doc/BRIEF.md
# Infrared-Mode Flat Interrupt Aggregator

This block gathers the eight interrupt sources of a serial port running in infrared mode into one interrupt line. Each source has its own enable bit. Each source also has a status bit in an identification bitmap. The line is raised whenever any enabled source is pending. The sources carry no priority and no encoding, so software reads the bitmap and services every bit it finds set.

Two of the sources track a level.
- The receive source follows data-ready when the FIFOs are off. When the FIFOs are on, it follows the receive FIFO fill level being above its trigger threshold.
- The transmit source follows holding-register-empty when the FIFOs are off. When the FIFOs are on, it follows the transmit FIFO level being below its threshold.

These two bits go away only when their condition goes away, for example after the data is drained or the FIFO is refilled. The other six sources are one-cycle event pulses. Each pulse is caught in a sticky flag, and reading the identification bitmap clears the flags.

A small register port gives access to the enable mask and to the bitmap. Both are 8 bits wide.

Top module: `irda_irq_agg`

## Requirements
- R1: After reset the enable mask reads 0x00, the identification bitmap reads 0x00 and `irq_out` is low.
- R2: `irq_out` is high exactly when the identification bitmap is nonzero. It is never high while the enable mask is zero.
- R3: Address 0 holds the enable mask. A write updates it on the clock edge, and a read returns it. Bit i enables source i, where bit 0 is receive, bit 1 is transmit, and bits 2 to 7 are `evt_pulse[0]` to `evt_pulse[5]`.
- R4: When `fifo_en` is 0, identification bit 0 equals `rx_data_ready` as sampled on the previous edge, ANDed with enable bit 0.
- R5: When `fifo_en` is 1, identification bit 0 is set one cycle after `rx_level` > `rx_trig`. It is clear when the level equals the threshold.
- R6: When `fifo_en` is 0, identification bit 1 equals `tx_holding_empty` as sampled on the previous edge, ANDed with enable bit 1.
- R7: When `fifo_en` is 1, identification bit 1 is set one cycle after `tx_level` < `tx_trig`. It is clear when the level equals the threshold.
- R8: Bits 0 and 1 are not latched. One cycle after their condition drops, they read 0 and no longer drive `irq_out`.
- R9: A one-cycle high on `evt_pulse[k]` while enable bit k+2 is set makes bit k+2 read 1 from the next cycle on. A pulse while that enable bit is 0 is dropped.
- R10: Reading address 1 returns the current bitmap and clears every sticky flag at that edge. A pulse arriving in the same cycle as the read stays set.
- R11: Writing a 0 to enable bit k+2 also discards any pending flag for that source. This holds even when a pulse arrives in the same cycle.
- R12: Writes to address 1 have no effect. Reads of addresses 2 and 3 return 0x00. Reading address 0 does not clear any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | FIFOs enabled; selects threshold sources for bits 0 and 1 |
| rx_data_ready | input | 1 | Receive holding register has data (FIFO off) |
| rx_level | input | 6 | Receive FIFO fill level |
| rx_trig | input | 6 | Receive trigger threshold |
| tx_holding_empty | input | 1 | Transmit holding register empty (FIFO off) |
| tx_level | input | 6 | Transmit FIFO fill level |
| tx_trig | input | 6 | Transmit trigger threshold |
| evt_pulse | input | 6 | One-cycle event pulses for sources 2 to 7 |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address (0 enable mask, 1 identification) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from current state |
| irq_out | output | 1 | Interrupt line |

## Verification
Level conditions and event pulses appear in the bitmap and on `irq_out` one edge after they are sampled. An enable write takes effect on the edge that follows the write. Read data is valid in the same cycle as the read strobe, and the clear that follows a read lands on that same edge.

The bench drives the inputs just after a falling edge. It compares read data and `irq_out` 1 ns later, before the rising edge. It then advances a bench model by exactly one edge, so every comparison is made against the state after the latest edge.

Directed cases cover the following:
- equal-to-threshold levels;
- a pulse in the same cycle as a read;
- a pulse in the same cycle as a disable;
- writes to the read-only address.

A seeded random phase then mixes every input.

// File: rtl/irda_irq_pkg.sv
package irda_irq_pkg;
  localparam int unsigned NUM_SRC  = 8;
  localparam int unsigned NUM_LVL  = 2;
  localparam int unsigned NUM_EVT  = NUM_SRC - NUM_LVL;
  localparam int unsigned ADDR_W   = 2;
  localparam int unsigned LVL_RX   = 0;
  localparam int unsigned LVL_TX   = 1;

  typedef enum logic [ADDR_W-1:0] {
    REG_ENABLE = 2'd0,
    REG_IDENT  = 2'd1,
    REG_RSVD2  = 2'd2,
    REG_RSVD3  = 2'd3
  } reg_addr_e;

  typedef logic [NUM_SRC-1:0] src_vec_t;
  typedef logic [NUM_EVT-1:0] evt_vec_t;
  typedef logic [NUM_LVL-1:0] lvl_vec_t;
endpackage

// File: rtl/irda_irq_regif.sv
module irda_irq_regif
  import irda_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [NUM_SRC-1:0] reg_wdata,
  input  logic [NUM_SRC-1:0] ident,
  output logic [NUM_SRC-1:0] en_q,
  output logic [NUM_SRC-1:0] en_d,
  output logic              ident_rd,
  output logic [NUM_SRC-1:0] reg_rdata
);
  logic en_wr;

  always_comb begin
    en_wr    = reg_wr && (reg_addr == REG_ENABLE);
    ident_rd = reg_rd && (reg_addr == REG_IDENT);
    en_d     = en_wr ? reg_wdata : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else if (en_wr) en_q <= en_d;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      unique case (reg_addr)
        REG_ENABLE: reg_rdata = en_q;
        REG_IDENT:  reg_rdata = ident;
        default:    reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/irda_irq_level.sv
module irda_irq_level
  import irda_irq_pkg::*;
#(
  parameter int unsigned LVL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic             rx_data_ready,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] rx_trig,
  input  logic             tx_holding_empty,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] tx_trig,
  output logic [NUM_LVL-1:0] lvl_q
);
  logic [NUM_LVL-1:0] lvl_d;

  always_comb begin
    lvl_d = '0;
    lvl_d[LVL_RX] = fifo_en ? (rx_level > rx_trig) : rx_data_ready;
    lvl_d[LVL_TX] = fifo_en ? (tx_level < tx_trig) : tx_holding_empty;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_d;
  end
endmodule

// File: rtl/irda_irq_events.sv
module irda_irq_events
  import irda_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_pulse,
  input  logic [NUM_EVT-1:0] evt_en_cur,
  input  logic [NUM_EVT-1:0] evt_en_next,
  input  logic               clr_all,
  output logic [NUM_EVT-1:0] sticky_q
);
  for (genvar k = 0; k < NUM_EVT; k++) begin : g_flag
    logic flag_d;
    logic flag_ce;
    always_comb begin
      flag_ce = clr_all || evt_pulse[k] || !evt_en_next[k];
      flag_d  = ((sticky_q[k] && !clr_all) || (evt_pulse[k] && evt_en_cur[k]))
                && evt_en_next[k];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sticky_q[k] <= 1'b0;
      else if (flag_ce) sticky_q[k] <= flag_d;
    end
  end
endmodule

// File: rtl/irda_irq_agg.sv
module irda_irq_agg
  import irda_irq_pkg::*;
#(
  parameter int unsigned LVL_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fifo_en,
  input  logic               rx_data_ready,
  input  logic [LVL_W-1:0]   rx_level,
  input  logic [LVL_W-1:0]   rx_trig,
  input  logic               tx_holding_empty,
  input  logic [LVL_W-1:0]   tx_level,
  input  logic [LVL_W-1:0]   tx_trig,
  input  logic [NUM_EVT-1:0] evt_pulse,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [NUM_SRC-1:0] reg_wdata,
  output logic [NUM_SRC-1:0] reg_rdata,
  output logic               irq_out
);
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] en_d;
  logic               ident_rd;
  logic [NUM_LVL-1:0] lvl_q;
  logic [NUM_EVT-1:0] sticky_q;
  logic [NUM_SRC-1:0] ident;

  irda_irq_regif u_regif (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .ident    (ident),
    .en_q     (en_q),
    .en_d     (en_d),
    .ident_rd (ident_rd),
    .reg_rdata(reg_rdata)
  );

  irda_irq_level #(.LVL_W(LVL_W)) u_level (
    .clk             (clk),
    .rst_n           (rst_n),
    .fifo_en         (fifo_en),
    .rx_data_ready   (rx_data_ready),
    .rx_level        (rx_level),
    .rx_trig         (rx_trig),
    .tx_holding_empty(tx_holding_empty),
    .tx_level        (tx_level),
    .tx_trig         (tx_trig),
    .lvl_q           (lvl_q)
  );

  irda_irq_events u_events (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_pulse  (evt_pulse),
    .evt_en_cur (en_q[NUM_SRC-1:NUM_LVL]),
    .evt_en_next(en_d[NUM_SRC-1:NUM_LVL]),
    .clr_all    (ident_rd),
    .sticky_q   (sticky_q)
  );

  always_comb begin
    ident   = {sticky_q, lvl_q} & en_q;
    irq_out = |ident;
  end
endmodule

// File: rtl/irda_irq_agg_chk.sv
module irda_irq_agg_chk
  import irda_irq_pkg::*;
#(
  parameter int unsigned LVL_W = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               fifo_en,
  input logic               rx_data_ready,
  input logic [LVL_W-1:0]   tx_level,
  input logic [LVL_W-1:0]   tx_trig,
  input logic [NUM_EVT-1:0] evt_pulse,
  input logic               reg_wr,
  input logic               reg_rd,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [NUM_SRC-1:0] reg_wdata,
  input logic [NUM_SRC-1:0] en_q,
  input logic [NUM_EVT-1:0] sticky_q,
  input logic               irq_out
);
  // R2
  no_irq_when_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq_out);

  // R4
  rx_ready_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!fifo_en && rx_data_ready) && en_q[LVL_RX]) |-> irq_out);

  // R7
  tx_below_trig_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fifo_en && (tx_level < tx_trig)) && en_q[LVL_TX]) |-> irq_out);

  // R9
  evt_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_wr && reg_addr == REG_ENABLE) |->
      (($past(evt_pulse) & $past(en_q[NUM_SRC-1:NUM_LVL]) & ~sticky_q) == '0));

  // R10
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_rd && reg_addr == REG_IDENT) |->
      ((sticky_q & ~$past(evt_pulse)) == '0));

  // R11
  disable_drops_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_wr && reg_addr == REG_ENABLE) |->
      ((sticky_q & ~$past(reg_wdata[NUM_SRC-1:NUM_LVL])) == '0));

  // R12
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_rd && reg_addr == REG_IDENT) && !$past(reg_wr && reg_addr == REG_ENABLE) |->
      ((($past(sticky_q)) & ~sticky_q) == '0));
endmodule

bind irda_irq_agg irda_irq_agg_chk #(.LVL_W(LVL_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fifo_en      (fifo_en),
  .rx_data_ready(rx_data_ready),
  .tx_level     (tx_level),
  .tx_trig      (tx_trig),
  .evt_pulse    (evt_pulse),
  .reg_wr       (reg_wr),
  .reg_rd       (reg_rd),
  .reg_addr     (reg_addr),
  .reg_wdata    (reg_wdata),
  .en_q         (en_q),
  .sticky_q     (sticky_q),
  .irq_out      (irq_out)
);

// File: tb/irda_irq_agg_tb.sv
module irda_irq_agg_tb;
  localparam int LW = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          fifo_en, rx_data_ready, tx_holding_empty;
  logic [LW-1:0] rx_level, rx_trig, tx_level, tx_trig;
  logic [5:0]    evt_pulse;
  logic          reg_wr, reg_rd;
  logic [1:0]    reg_addr;
  logic [7:0]    reg_wdata, reg_rdata;
  logic          irq_out;

  int n_cmp = 0;
  int n_bad = 0;

  logic [7:0] m_en;
  logic [1:0] m_lvl;
  logic [5:0] m_sticky;

  always #4 clk = ~clk;

  irda_irq_agg #(.LVL_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_data_ready(rx_data_ready),
    .rx_level(rx_level), .rx_trig(rx_trig), .tx_holding_empty(tx_holding_empty),
    .tx_level(tx_level), .tx_trig(tx_trig), .evt_pulse(evt_pulse),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  function automatic logic [7:0] exp_ident();
    return {m_sticky, m_lvl} & m_en;
  endfunction

  function automatic logic [7:0] exp_rdata();
    if (!reg_rd) return 8'h00;
    case (reg_addr)
      2'd0:    return m_en;
      2'd1:    return exp_ident();
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    fifo_en = 0; rx_data_ready = 0; tx_holding_empty = 0;
    rx_level = 0; rx_trig = 0; tx_level = 0; tx_trig = 0;
    evt_pulse = 0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
  endtask

  task automatic tick(string req);
    logic [1:0] nl;
    logic [7:0] ne;
    #1;
    check(req, "irq_out", {7'b0, irq_out}, {7'b0, |exp_ident()});
    if (reg_rd) check(req, "rdata", reg_rdata, exp_rdata());
    nl[0] = fifo_en ? (rx_level > rx_trig) : rx_data_ready;
    nl[1] = fifo_en ? (tx_level < tx_trig) : tx_holding_empty;
    ne = (reg_wr && reg_addr == 2'd0) ? reg_wdata : m_en;
    m_sticky = ((m_sticky & ~{6{reg_rd && reg_addr == 2'd1}}) | (evt_pulse & m_en[7:2])) & ne[7:2];
    m_lvl = nl;
    m_en = ne;
    @(negedge clk);
    idle();
  endtask

  task automatic rd(string req, logic [1:0] a);
    reg_rd = 1; reg_addr = a;
    tick(req);
  endtask

  task automatic wr(string req, logic [1:0] a, logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    tick(req);
  endtask

  initial begin
    #1_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5eed_1a2b);
    idle();
    rst_n = 0;
    m_en = 0; m_lvl = 0; m_sticky = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd("R1", 2'd0);
    rd("R1", 2'd1);

    // R3 enable readback
    wr("R3", 2'd0, 8'hA5);
    rd("R3", 2'd0);
    wr("R3", 2'd0, 8'hFF);

    // R4 data ready, FIFO off
    rx_data_ready = 1; tick("R4");
    rd("R4", 2'd1);
    // R8 drop when condition goes
    tick("R8");
    rd("R8", 2'd1);

    // R5 rx above / equal threshold
    fifo_en = 1; rx_level = 6'd9; rx_trig = 6'd8; tick("R5");
    rd("R5", 2'd1);
    fifo_en = 1; rx_level = 6'd8; rx_trig = 6'd8; tick("R5");
    rd("R5", 2'd1);

    // R6 holding empty
    tx_holding_empty = 1; tick("R6");
    rd("R6", 2'd1);

    // R7 tx below / equal threshold
    fifo_en = 1; tx_level = 6'd3; tx_trig = 6'd4; tick("R7");
    rd("R7", 2'd1);
    fifo_en = 1; tx_level = 6'd4; tx_trig = 6'd4; tick("R7");
    rd("R7", 2'd1);

    // R9 sticky capture, masked pulse dropped
    evt_pulse = 6'b000101; tick("R9");
    tick("R9");
    rd("R9", 2'd1);
    wr("R9", 2'd0, 8'b1111_0111);
    evt_pulse = 6'b000010; tick("R9");
    rd("R9", 2'd1);
    // R12 enable read does not clear, write to ident ignored
    evt_pulse = 6'b100000; tick("R12");
    rd("R12", 2'd0);
    wr("R12", 2'd1, 8'h00);
    rd("R12", 2'd1);
    rd("R12", 2'd2);
    rd("R12", 2'd3);
    // R10 read clears; same-cycle pulse survives
    reg_rd = 1; reg_addr = 2'd1; evt_pulse = 6'b010000; tick("R10");
    rd("R10", 2'd1);
    rd("R10", 2'd1);
    // R11 disable drops flag, even with same-cycle pulse
    evt_pulse = 6'b001000; tick("R11");
    reg_wr = 1; reg_addr = 2'd0; reg_wdata = 8'h0F; evt_pulse = 6'b000011; tick("R11");
    rd("R11", 2'd1);
    wr("R11", 2'd0, 8'hFF);
    rd("R11", 2'd1);
    // R2 masked sources never raise the line
    wr("R2", 2'd0, 8'h00);
    rx_data_ready = 1; tx_holding_empty = 1; evt_pulse = 6'h3F; tick("R2");
    tick("R2");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      fifo_en = r[0];
      rx_data_ready = r[1];
      tx_holding_empty = r[2];
      rx_level = LW'($urandom_range(0, 15));
      rx_trig  = LW'($urandom_range(0, 15));
      tx_level = LW'($urandom_range(0, 15));
      tx_trig  = LW'($urandom_range(0, 15));
      evt_pulse = (r[5:3] == 0) ? 6'(r[31:26]) : 6'h00;
      reg_rd = r[6] & r[7];
      reg_wr = (r[8] & r[9] & r[10]) && !reg_rd;
      reg_addr = r[12:11];
      reg_wdata = r[20:13];
      tick("R2");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule